// File: doc/BRIEF.md
# Transmit-Only Serial Memory Streamer

This block streams a 128-byte table onto a shared open-drain data line. Each rising edge of a dedicated transmit clock sends one bit. After reset the block waits through a start-up phase of nine transmit clocks. During that phase it sets no bit on the line. It reads the line level on the first eight of those clocks to choose where the stream begins. It then sends bytes most significant bit first. A ninth slot follows each byte, in which the line is left released. The address steps up after every byte and wraps around at the top of the table.

The block also holds a one-way mode latch. A clean falling edge on the second bus clock moves the block into bidirectional mode. A falling edge is clean when the bus clock was high for at least two system clocks before it. In bidirectional mode the streamer lets go of the line and ignores the transmit clock until the next reset. All three inputs pass through a two-stage synchronizer into the system clock domain. The block never drives the line high. It only asserts a pull-low enable.

The FSM has three states. `ST_INIT` counts the nine start-up clocks. On the ninth it moves to `ST_SEND` and loads the start address. `ST_SEND` shifts out the bits and the released slot. Both `ST_INIT` and `ST_SEND` move to `ST_EXIT` when the mode latch is set. `ST_EXIT` is terminal until reset.

Top module: `txo_streamer`

## Requirements
- R1: After reset `bidir_mode` is 0 and `line_pull_low` is 0. `line_pull_low` stays 0 during all nine start-up transmit clocks.
- R2: If the line reads high on all of the first eight start-up clocks, the first byte sent is address 0x7F. Otherwise the first byte sent is address 0x00. The line level on the ninth start-up clock has no effect.
- R3: Each transmit-clock rising edge in the sending phase presents the next bit, most significant first. A 0 bit sets `line_pull_low`=1 and a 1 bit sets it to 0. The value holds until the next rising edge.
- R4: After the eighth bit of every byte, one more transmit clock gives a slot with `line_pull_low`=0.
- R5: The byte stored at address a is (29·a + 0x5A) mod 256.
- R6: The address steps by one after each nine-slot frame and wraps from 0x7F to 0x00 without a pause.
- R7: A falling edge of `bclk_in` that follows at least two system clocks of high level sets `bidir_mode` on the third system clock edge after the input falls.
- R8: A high pulse on `bclk_in` that lasts one system clock does not change the mode, and the stream continues unchanged.
- R9: Once `bidir_mode` is 1, `line_pull_low` is 0 from the next system clock edge onward, whatever the transmit clock does.
- R10: `bidir_mode` stays 1 through any later bus-clock activity and returns to 0 only through reset.
- R11: A rising edge on `xclk_in` changes `line_pull_low` on the third system clock edge after the input rises, and not sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| xclk_in | input | 1 | Transmit clock, asynchronous, held low through reset |
| bclk_in | input | 1 | Bidirectional-bus clock, asynchronous |
| line_in | input | 1 | Sampled level of the shared data line |
| line_pull_low | output | 1 | Pull-low enable for the open-drain data line |
| bidir_mode | output | 1 | 1 once the block has left transmit-only mode |

## Verification
Each transmit-clock rising edge changes `line_pull_low` on the third system clock edge after the bench raises `xclk_in`. The bench samples on the falling clock edge after two edges and expects the old value. It samples again after three or more edges and expects the new bit. After a qualified falling edge on `bclk_in`, `bidir_mode` is checked as 0 after two edges and as 1 after three, and the line release is checked one edge later. Start-up line levels go through the same synchronizer depth as the transmit clock, so each is set together with its clock and is due at the same edge.

// File: rtl/txo_pkg.sv
package txo_pkg;

    localparam int unsigned ADDR_W_DEF     = 7;
    localparam int unsigned DATA_W_DEF     = 8;
    localparam int unsigned SYNC_DEPTH_DEF = 2;
    localparam int unsigned QUAL_CYC_DEF   = 2;
    localparam int unsigned PAT_MUL_DEF    = 29;
    localparam int unsigned PAT_ADD_DEF    = 90;

    typedef enum logic [1:0] {
        ST_INIT = 2'd0,
        ST_SEND = 2'd1,
        ST_EXIT = 2'd2
    } txo_state_e;

endpackage

// File: rtl/txo_sync.sv
// Multi-bit two-or-more stage synchronizer into the system clock domain.
module txo_sync #(
    parameter int unsigned W     = 3,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [DEPTH-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= {stg_q[DEPTH-2:0], d};
        end
    end

    assign q = stg_q[DEPTH-1];
endmodule

// File: rtl/txo_edge.sv
// Single edge detector; FALLING picks which edge is reported.
module txo_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= lvl;
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~lvl;
        end else begin : g_rise
            assign edge_o = lvl & ~prev_q;
        end
    endgenerate
endmodule

// File: rtl/txo_mode_latch.sv
// One-way latch: set by a bus-clock falling edge preceded by QUAL high samples.
module txo_mode_latch #(
    parameter int unsigned QUAL = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_lvl,
    output logic bidir_o
);
    localparam int unsigned CNT_W = $clog2(QUAL + 1);

    logic [CNT_W-1:0] hi_cnt_q;
    logic             fall;
    logic             qualified;

    txo_edge #(.FALLING(1'b1)) u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (bus_lvl),
        .edge_o (fall)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!bus_lvl) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q != CNT_W'(QUAL)) begin
            hi_cnt_q <= hi_cnt_q + CNT_W'(1);
        end
    end

    assign qualified = fall && (hi_cnt_q == CNT_W'(QUAL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidir_o <= 1'b0;
        end else if (qualified) begin
            bidir_o <= 1'b1;
        end
    end
endmodule

// File: rtl/txo_byte_rom.sv
// Table contents computed from an affine pattern of the address.
module txo_byte_rom #(
    parameter int unsigned ADDR_W  = 7,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned PAT_MUL = 29,
    parameter int unsigned PAT_ADD = 90
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] tbl;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            assign tbl[g] = DATA_W'(g * PAT_MUL + PAT_ADD);
        end
    endgenerate

    assign data = tbl[addr];
endmodule

// File: rtl/txo_stream_fsm.sv
// Start-up, bit framing and address sequencing for the transmit-only stream.
module txo_stream_fsm
    import txo_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xrise,
    input  logic              line_lvl,
    input  logic              exit_req,
    input  logic [DATA_W-1:0] rom_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              pull_low
);
    localparam int unsigned FRAME    = DATA_W + 1;
    localparam int unsigned CNT_W    = $clog2(FRAME + 1);
    localparam int unsigned SLOT_W   = $clog2(DATA_W + 1);
    localparam int unsigned BIT_W    = $clog2(DATA_W);

    txo_state_e        state_q, state_d;
    logic [CNT_W-1:0]  init_cnt_q;
    logic              all_high_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SLOT_W-1:0] slot_q;
    logic              pull_q;
    logic [BIT_W-1:0]  bit_idx;
    logic              last_init;

    assign last_init = (init_cnt_q == CNT_W'(FRAME - 1));
    assign bit_idx   = BIT_W'(DATA_W - 1) - slot_q[BIT_W-1:0];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (exit_req) begin
                    state_d = ST_EXIT;
                end else if (xrise && last_init) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (exit_req) begin
                    state_d = ST_EXIT;
                end
            end
            ST_EXIT: state_d = ST_EXIT;
            default: state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt_q <= '0;
            all_high_q <= 1'b1;
            addr_q     <= '0;
            slot_q     <= '0;
            pull_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_INIT: begin
                    pull_q <= 1'b0;
                    if (!exit_req && xrise) begin
                        init_cnt_q <= init_cnt_q + CNT_W'(1);
                        if (!last_init) begin
                            all_high_q <= all_high_q & line_lvl;
                        end else begin
                            addr_q <= all_high_q ? {ADDR_W{1'b1}} : '0;
                            slot_q <= '0;
                        end
                    end
                end
                ST_SEND: begin
                    if (exit_req) begin
                        pull_q <= 1'b0;
                    end else if (xrise) begin
                        if (slot_q < SLOT_W'(DATA_W)) begin
                            pull_q <= ~rom_data[bit_idx];
                            slot_q <= slot_q + SLOT_W'(1);
                        end else begin
                            pull_q <= 1'b0;
                            slot_q <= '0;
                            addr_q <= addr_q + ADDR_W'(1);
                        end
                    end
                end
                ST_EXIT: pull_q <= 1'b0;
                default: pull_q <= 1'b0;
            endcase
        end
    end

    assign rd_addr  = addr_q;
    assign pull_low = pull_q;
endmodule

// File: rtl/txo_streamer.sv
// Top: synchronizers, mode latch, byte table and stream sequencer.
module txo_streamer
    import txo_pkg::*;
#(
    parameter int unsigned ADDR_W     = ADDR_W_DEF,
    parameter int unsigned DATA_W     = DATA_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF,
    parameter int unsigned QUAL_CYC   = QUAL_CYC_DEF,
    parameter int unsigned PAT_MUL    = PAT_MUL_DEF,
    parameter int unsigned PAT_ADD    = PAT_ADD_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xclk_in,
    input  logic bclk_in,
    input  logic line_in,
    output logic line_pull_low,
    output logic bidir_mode
);
    localparam int unsigned N_SYNC = 3;

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_lvl;
    logic              xclk_lvl;
    logic              bclk_lvl;
    logic              line_lvl;
    logic              xclk_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rom_data;

    assign raw_in   = {line_in, bclk_in, xclk_in};
    assign xclk_lvl = sync_lvl[0];
    assign bclk_lvl = sync_lvl[1];
    assign line_lvl = sync_lvl[2];

    txo_sync #(.W(N_SYNC), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_lvl)
    );

    txo_edge #(.FALLING(1'b0)) u_xrise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (xclk_lvl),
        .edge_o (xclk_rise)
    );

    txo_mode_latch #(.QUAL(QUAL_CYC)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_lvl (bclk_lvl),
        .bidir_o (bidir_mode)
    );

    txo_byte_rom #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PAT_MUL (PAT_MUL),
        .PAT_ADD (PAT_ADD)
    ) u_rom (
        .addr (rd_addr),
        .data (rom_data)
    );

    txo_stream_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .xrise    (xclk_rise),
        .line_lvl (line_lvl),
        .exit_req (bidir_mode),
        .rom_data (rom_data),
        .rd_addr  (rd_addr),
        .pull_low (line_pull_low)
    );
endmodule

// File: rtl/txo_streamer_chk.sv
module txo_streamer_chk
    import txo_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       xclk_rise,
    input logic       bclk_lvl,
    input logic       bidir_mode,
    input logic       line_pull_low,
    input txo_state_e state
);
    p_quiet_in_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INIT) |-> !line_pull_low);

    p_pull_after_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_pull_low) |-> $past(xclk_rise));

    p_exit_on_low_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bidir_mode) |-> !$past(bclk_lvl));

    p_release_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |=> !line_pull_low);

    p_mode_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bidir_mode |=> bidir_mode);
endmodule

bind txo_streamer txo_streamer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xclk_rise     (xclk_rise),
    .bclk_lvl      (bclk_lvl),
    .bidir_mode    (bidir_mode),
    .line_pull_low (line_pull_low),
    .state         (u_fsm.state_q)
);

// File: tb/txo_streamer_test.sv
module txo_streamer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xclk_in = 1'b0;
    logic bclk_in = 1'b1;
    logic line_in = 1'b1;
    logic line_pull_low;
    logic bidir_mode;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [6:0] exp_addr = '0;
    int bslot = 0;

    always #5 clk = ~clk;

    txo_streamer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .xclk_in       (xclk_in),
        .bclk_in       (bclk_in),
        .line_in       (line_in),
        .line_pull_low (line_pull_low),
        .bidir_mode    (bidir_mode)
    );

    function automatic logic [7:0] exp_byte(input logic [6:0] a);
        return 8'((int'(a) * 29 + 90) % 256);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic xpulse(input string tag, input logic exp_pull);
        logic prev;
        int half;
        half = 3 + int'($urandom_range(4, 0));
        prev = line_pull_low;
        xclk_in = 1'b1;
        wait_neg(2);
        check("R11", int'(line_pull_low), int'(prev));
        wait_neg(half - 2);
        check(tag, int'(line_pull_low), int'(exp_pull));
        xclk_in = 1'b0;
        wait_neg(half);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        xclk_in = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(2);
        check("R1", int'(line_pull_low), 0);
        check("R10", int'(bidir_mode), 0);
    endtask

    task automatic run_init(input logic [7:0] pat);
        for (int k = 0; k < 9; k++) begin
            line_in = (k < 8) ? pat[7-k] : 1'b0;
            xpulse("R1", 1'b0);
        end
        line_in = 1'b1;
        exp_addr = (pat == 8'hFF) ? 7'h7F : 7'h00;
        bslot = 0;
    endtask

    task automatic emit_slot(input string tag);
        logic [7:0] b;
        b = exp_byte(exp_addr);
        if (bslot < 8) begin
            xpulse(tag, ~b[7-bslot]);
            bslot++;
        end else begin
            xpulse("R4", 1'b0);
            bslot = 0;
            exp_addr = exp_addr + 7'd1;
        end
    endtask

    task automatic emit_byte(input string tag);
        for (int i = 0; i < 9; i++) emit_slot(tag);
    endtask

    task automatic do_exit();
        bclk_in = 1'b0;
        wait_neg(2);
        check("R11", int'(bidir_mode), 0);
        wait_neg(1);
        check("R7", int'(bidir_mode), 1);
        wait_neg(1);
        check("R9", int'(line_pull_low), 0);
        for (int i = 0; i < 10; i++) xpulse("R9", 1'b0);
        bclk_in = 1'b1;
        wait_neg(4);
        bclk_in = 1'b0;
        wait_neg(4);
        check("R10", int'(bidir_mode), 1);
        bclk_in = 1'b1;
        wait_neg(2);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20250611);

        // start 0x7F, wrap on the second byte
        bclk_in = 1'b1;
        do_reset();
        run_init(8'hFF);
        emit_byte("R2");
        emit_byte("R6");
        emit_byte("R5");

        // bus clock low from reset: short pulse ignored, two-cycle pulse qualifies
        bclk_in = 1'b0;
        do_reset();
        run_init(8'hFE);
        emit_byte("R2");
        bclk_in = 1'b1;
        wait_neg(1);
        bclk_in = 1'b0;
        wait_neg(6);
        check("R8", int'(bidir_mode), 0);
        emit_byte("R8");
        emit_byte("R8");
        bclk_in = 1'b1;
        wait_neg(2);
        do_exit();

        // start 0x00, full lap around the table
        do_reset();
        run_init(8'h00);
        emit_byte("R2");
        for (int i = 0; i < 129; i++) emit_byte("R6");
        for (int i = 0; i < 3; i++) emit_slot("R3");
        do_exit();

        // random start patterns, lengths and exit points
        for (int r = 0; r < 4; r++) begin
            logic [7:0] pat;
            int nb;
            int ns;
            pat = ($urandom_range(1, 0) == 1) ? 8'hFF : 8'($urandom);
            nb = int'($urandom_range(5, 1));
            ns = int'($urandom_range(8, 0));
            bclk_in = 1'b1;
            do_reset();
            run_init(pat);
            for (int i = 0; i < nb; i++) emit_byte("R3");
            for (int i = 0; i < ns; i++) emit_slot("R5");
            do_exit();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule